// File: doc/BRIEF.md
# Dual Missed-Frame Diagnostic Counter

This block is a read-only status word for the receive side of a DMA path. It holds two event counters. The first counts frames that the DMA discarded because no host receive buffer was free. The second counts frames lost to receive FIFO or MAC overflow, including short good frames (under 64 bytes) that the FIFO logic dropped. Each counter has a sticky flag that records a wrap past its all-ones value.

The read value comes straight from the held state. During a read strobe the word presents the value before the clear. On the clock edge that ends the strobe, each counter whose byte-enable lane is set returns to zero, and its flag clears with it. Software cannot write any field. The bus decode, the FIFO and the DMA sit outside this block.

Top module: `mfc_status_reg`

## Requirements
- R1: After reset, every bit of `rd_data_o` reads 0.
- R2: Bits [15:0] hold a 16-bit count of buffer-unavailable discards. The count rises by one on each clock edge where `nobuf_drop_i` is 1.
- R3: Bits [27:17] hold an 11-bit count of overflow and runt losses. The count rises by one on each clock edge where `rx_ovf_i` is 1.
- R4: A read (`rd_en_i`=1) with `rd_be_i[0]`=1 shows the current bits [16:0] in that cycle. After that edge, the 16-bit count and its flag are 0.
- R5: A read with `rd_be_i[2]`=1 shows the current bits [28:17] in that cycle. After that edge, the 11-bit count and its flag are 0.
- R6: A read without the matching byte-enable bit leaves that counter unchanged. So does any byte-enable pattern while `rd_en_i`=0. Example: `rd_be_i`=4'b1010 clears neither counter.
- R7: When the 16-bit count steps from 16'hFFFF to 0, bit 16 becomes 1. It stays 1 until a read clear of that counter.
- R8: When the 11-bit count steps from 11'h7FF to 0, bit 28 becomes 1. It stays 1 until a read clear of that counter.
- R9: If an increment and a read clear of the same counter fall in the same cycle, that counter reads 1 afterwards and its flag reads 0.
- R10: Bits [31:29] always read 0.
- R11: Pulses and clears on one counter have no effect on the other. This holds even when all of them fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nobuf_drop_i | input | 1 | One-cycle pulse: DMA discarded a frame, no host buffer |
| rx_ovf_i | input | 1 | One-cycle pulse: frame lost to overflow or runt drop |
| rd_en_i | input | 1 | Register read strobe |
| rd_be_i | input | 4 | Byte enables of the read |
| rd_data_o | output | 32 | Packed status word, pre-clear value |

## Verification
The counters are driven with three kinds of traffic.

- **Bursts on one source only.** These show that each event reaches only its own field.
- **Pulses that coincide with clears.** These separate a design that loses the event from one that keeps it at 1.
- **Byte-enable patterns that cover one lane, both lanes or neither lane,** with and without the strobe. These show which lane key drives each clear.

Long runs of 2048 and 65536 pulses push each counter over its wrap. They check that the flag sets, that it survives reads of the other lane, and that it falls only on its own clear.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    localparam int WORD_W     = 32;
    localparam int BE_W       = 4;
    localparam int NOBUF_W    = 16;
    localparam int OVF_W      = 11;
    localparam int NOBUF_LANE = 0;
    localparam int OVF_LANE   = 2;
endpackage

// File: rtl/mfc_clear_decode.sv
module mfc_clear_decode #(
    parameter int BE_W   = 4,
    parameter int LANE_A = 0,
    parameter int LANE_B = 2
) (
    input  logic            rd_en_i,
    input  logic [BE_W-1:0] rd_be_i,
    output logic            clr_a_o,
    output logic            clr_b_o
);
    logic unused_be;
    assign unused_be = ^rd_be_i;

    always_comb begin
        clr_a_o = rd_en_i & rd_be_i[LANE_A];
        clr_b_o = rd_en_i & rd_be_i[LANE_B];
    end
endmodule

// File: rtl/mfc_event_counter.sv
module mfc_event_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrapped_o
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             wrapped;
    } state_t;

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.wrapped = 1'b0;
            st_d.count   = inc_i ? ONE : '0;
        end else if (inc_i) begin
            st_d.count = st_q.count + ONE;
            if (&st_q.count) begin
                st_d.wrapped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign wrapped_o = st_q.wrapped;

    AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !inc_i |=> count_o == '0 && !wrapped_o); // R4
    AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && inc_i |=> count_o == ONE && !wrapped_o); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !inc_i |=> $stable(count_o) && $stable(wrapped_o)); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && inc_i |=> count_o == WIDTH'($past(count_o) + ONE)); // R2
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && inc_i && (&count_o) |=> wrapped_o); // R7
    AST_FLAG_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrapped_o) |-> $past(clr_i)); // R7
endmodule

// File: rtl/mfc_word_pack.sv
module mfc_word_pack #(
    parameter int WORD_W = 32,
    parameter int A_W    = 16,
    parameter int B_W    = 11
) (
    input  logic [A_W-1:0]    cnt_a_i,
    input  logic              flag_a_i,
    input  logic [B_W-1:0]    cnt_b_i,
    input  logic              flag_b_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int A_FLAG_POS = A_W;
    localparam int B_LSB      = A_FLAG_POS + 1;
    localparam int B_FLAG_POS = B_LSB + B_W;

    always_comb begin
        word_o               = '0;
        word_o[A_W-1:0]      = cnt_a_i;
        word_o[A_FLAG_POS]   = flag_a_i;
        word_o[B_LSB +: B_W] = cnt_b_i;
        word_o[B_FLAG_POS]   = flag_b_i;
    end
endmodule

// File: rtl/mfc_status_reg.sv
module mfc_status_reg
    import mfc_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int BYTE_EN_W = BE_W,
    parameter int A_W      = NOBUF_W,
    parameter int B_W      = OVF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nobuf_drop_i,
    input  logic                 rx_ovf_i,
    input  logic                 rd_en_i,
    input  logic [BYTE_EN_W-1:0] rd_be_i,
    output logic [DATA_W-1:0]    rd_data_o
);
    localparam int USED_W = A_W + B_W + 2;

    logic           clr_a, clr_b;
    logic [A_W-1:0] cnt_a;
    logic [B_W-1:0] cnt_b;
    logic           flag_a, flag_b;

    mfc_clear_decode #(
        .BE_W  (BYTE_EN_W),
        .LANE_A(NOBUF_LANE),
        .LANE_B(OVF_LANE)
    ) u_dec (
        .rd_en_i(rd_en_i),
        .rd_be_i(rd_be_i),
        .clr_a_o(clr_a),
        .clr_b_o(clr_b)
    );

    mfc_event_counter #(.WIDTH(A_W)) u_nobuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (nobuf_drop_i),
        .clr_i    (clr_a),
        .count_o  (cnt_a),
        .wrapped_o(flag_a)
    );

    mfc_event_counter #(.WIDTH(B_W)) u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (rx_ovf_i),
        .clr_i    (clr_b),
        .count_o  (cnt_b),
        .wrapped_o(flag_b)
    );

    mfc_word_pack #(
        .WORD_W(DATA_W),
        .A_W   (A_W),
        .B_W   (B_W)
    ) u_pack (
        .cnt_a_i (cnt_a),
        .flag_a_i(flag_a),
        .cnt_b_i (cnt_b),
        .flag_b_i(flag_b),
        .word_o  (rd_data_o)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:USED_W] == '0); // R10
    AST_A_UNTOUCHED_BY_B: assert property (@(posedge clk) disable iff (!rst_n)
        !nobuf_drop_i && !(rd_en_i && rd_be_i[NOBUF_LANE])
        |=> $stable(rd_data_o[A_W:0])); // R11
    AST_B_UNTOUCHED_BY_A: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ovf_i && !(rd_en_i && rd_be_i[OVF_LANE])
        |=> $stable(rd_data_o[USED_W-1:A_W+1])); // R11
endmodule

// File: tb/tb_mfc_status_reg.sv
module tb_mfc_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drop = 1'b0;
    logic        ovf = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  be = 4'b0;
    logic [31:0] rdata;

    item_t  sb_q[$];
    event   ev_rd;
    int     total = 0;
    int     bad = 0;
    bit     done = 1'b0;

    int unsigned m_a = 0;
    int unsigned m_b = 0;
    bit          f_a = 1'b0;
    bit          f_b = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfc_status_reg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nobuf_drop_i(drop),
        .rx_ovf_i    (ovf),
        .rd_en_i     (rd),
        .rd_be_i     (be),
        .rd_data_o   (rdata)
    );

    function automatic logic [31:0] model_word();
        return {3'b000, f_b, m_b[10:0], f_a, m_a[15:0]};
    endfunction

    task automatic step(input logic d, input logic o, input logic r,
                        input logic [3:0] b, input string tag);
        @(negedge clk);
        drop = d; ovf = o; rd = r; be = b;
        #1;
        if (r) begin
            item_t it;
            it.exp = model_word();
            it.tag = tag;
            sb_q.push_back(it);
            ->ev_rd;
        end
        if (r && b[0]) begin
            m_a = d ? 1 : 0;
            f_a = 1'b0;
        end else if (d) begin
            if (m_a == 32'hFFFF) begin m_a = 0; f_a = 1'b1; end
            else m_a = m_a + 1;
        end
        if (r && b[2]) begin
            m_b = o ? 1 : 0;
            f_b = 1'b0;
        end else if (o) begin
            if (m_b == 32'h7FF) begin m_b = 0; f_b = 1'b1; end
            else m_b = m_b + 1;
        end
        @(posedge clk);
    endtask

    task automatic look(input string tag);
        step(1'b0, 1'b0, 1'b1, 4'b0000, tag);
    endtask

    initial begin : monitor
        forever begin
            @(ev_rd);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        look("R1 reset value");

        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 4'b0, "R2");
        look("R2 five discards");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 4'b0, "R3");
        look("R3 three overflows");

        step(1'b0, 1'b0, 1'b1, 4'b1010, "R6 be 1010 pre");
        look("R6 be 1010 clears neither");
        step(1'b0, 1'b0, 1'b0, 4'b1111, "R6 no strobe");
        look("R6 enables without strobe");

        step(1'b0, 1'b0, 1'b1, 4'b0001, "R4 pre-clear value");
        look("R4 lane0 cleared, lane2 kept");
        step(1'b0, 1'b0, 1'b1, 4'b0100, "R5 pre-clear value");
        look("R5 lane2 cleared");

        step(1'b1, 1'b0, 1'b0, 4'b0, "R9");
        step(1'b1, 1'b0, 1'b0, 4'b0, "R9");
        step(1'b1, 1'b0, 1'b1, 4'b0001, "R9 discard with clear");
        look("R9 discard kept as 1");
        step(1'b0, 1'b1, 1'b0, 4'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 4'b0100, "R9 overflow with clear");
        look("R9 overflow kept as 1");

        step(1'b1, 1'b1, 1'b1, 4'b0101, "R11 all at once");
        look("R11 both counters at 1");
        step(1'b1, 1'b1, 1'b1, 4'b0100, "R11 discard while lane2 clears");
        look("R11 independent update");
        step(1'b0, 1'b0, 1'b1, 4'b0101, "R11 clear both");
        look("R10 zero word");

        for (int i = 0; i < 2047; i++) step(1'b0, 1'b1, 1'b0, 4'b0, "R8");
        look("R8 at all ones");
        step(1'b0, 1'b1, 1'b0, 4'b0, "R8");
        look("R8 wrap sets flag");
        step(1'b0, 1'b1, 1'b0, 4'b0, "R8");
        step(1'b0, 1'b0, 1'b1, 4'b0001, "R8 flag across lane0 read");
        look("R8 flag sticky");
        step(1'b0, 1'b0, 1'b1, 4'b0100, "R8 clear");
        look("R8 flag cleared");

        for (int i = 0; i < 65535; i++) step(1'b1, 1'b0, 1'b0, 4'b0, "R7");
        look("R7 at all ones");
        step(1'b1, 1'b0, 1'b0, 4'b0, "R7");
        look("R7 wrap sets flag");
        step(1'b1, 1'b0, 1'b0, 4'b0, "R7");
        step(1'b0, 1'b0, 1'b1, 4'b0100, "R7 flag across lane2 read");
        look("R7 flag sticky");
        step(1'b0, 1'b0, 1'b1, 4'b0001, "R7 clear");
        look("R7 flag cleared");
        look("R10 reserved bits");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule